// File: doc/BRIEF.md
# I2C Target Responder with Sticky Status Flags

This block is the target (slave) side of a two-wire I2C link. A bus host drives SCL and SDA. Firmware controls and services the block through five byte-wide registers on a simple write-strobe and combinational-read port. The block watches the synchronized bus lines for START and STOP conditions and compares each address byte with a 7-bit own address. It then either takes bytes in from the host and acknowledges them, or shifts bytes out to the host MSB first. The general-call address can also be answered when firmware enables it.

Each bus event sets its own sticky flag in a status register. A flag stays set until firmware writes a 0 to its bit. A matching enable register selects which flags drive the single interrupt line. After the acknowledge bit, the block holds SCL low in two cases: a received byte has not yet been collected, or a byte to send has not yet been supplied. It releases SCL as soon as firmware clears the corresponding flag. The block only ever pulls the lines low; the pads and the pull-ups are outside it.

Register offsets: 0 control, 1 status, 2 interrupt enable, 3 own address (bits 6:0), 4 data port. Control bits: 0 force NACK, 1 general-call enable, 2 interface enable, 3 buffered data view. Status and interrupt-enable bits: 0 address matched, 1 byte received, 2 byte transmitted, 3 data port empty, 4 STOP seen, 5 host-read mode, 6 general call seen.

Top module: `i2c_target_top`

## Requirements
- R1: After reset, all five registers read 0, scl_oe, sda_oe and irq are low.
- R2: When the interface-enable bit is set and the address byte after a START carries the own address, the block pulls SDA low during the ninth clock and sets status bit 0. A non-matching address gets no acknowledge and sets no flag.
- R3: At an address match, status bit 5 takes the value of the R/W bit (1 = host reads). Writes to the status register never change bit 5.
- R4: In host-write mode, each received byte is acknowledged and sets status bit 1. With control bit 3 set, the data port returns the byte. SCL is pulled low from the fall after the acknowledge bit until bit 1 is cleared.
- R5: While control bit 0 is set, a received byte is answered with NACK. The byte is still stored and still sets status bit 1.
- R6: In host-read mode, after the address acknowledge and after each host ACK, status bit 3 is set and SCL is held low until bit 3 is cleared. The byte then in the data port is shifted out MSB first. Status bit 2 is set at each acknowledge bit of a transmitted byte.
- R7: A host NACK after a transmitted byte ends the read. Status bit 3 is not set, SCL is not held, and SDA is not driven until the next START.
- R8: A STOP that ends an addressed transfer sets status bit 4. A STOP after an unmatched address does not.
- R9: Address 0 with R/W = 0 is acknowledged only when control bit 1 is set, and then sets status bits 6 and 0.
- R10: Writing the status register clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R11: irq is high exactly when some status bit and the same interrupt-enable bit (offset 2) are both set.
- R12: With control bit 2 clear, the block acknowledges nothing and drives neither line.
- R13: With control bit 3 clear, the data port reads return the live shift register: during a byte they show the bits shifted in so far, appended below the older bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| scl_oe | output | 1 | Pull SCL low (clock stretching) |
| sda_oe | output | 1 | Pull SDA low (acknowledge or data 0) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Interrupt, OR of enabled status flags |

## Verification
A wrong bit counter or a wrong engine state shows at the ports within one SCL period. It appears as an acknowledge in the wrong bit slot, or as a transmitted byte that is shifted by one position when the host reads it. A flag that is set on the wrong event, or one that fails to clear, is seen on the next status read. It also shows as SCL staying pulled low, which would hang the host, so the stretch and release are checked within three system clocks of the clearing write. A wrongly latched R/W bit or a wrong forced-NACK response shows up at the same acknowledge slot as the byte it belongs to.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADR7_W = 7;
   localparam int STAT_W = 7;
   localparam int CTRL_W = 4;

   // status / interrupt-enable bit positions
   localparam int SB_ADDR   = 0;
   localparam int SB_RXD    = 1;
   localparam int SB_TXD    = 2;
   localparam int SB_EMPTY  = 3;
   localparam int SB_STOP   = 4;
   localparam int SB_TXMODE = 5;
   localparam int SB_GCALL  = 6;

   // control bit positions
   localparam int CB_FNACK = 0;
   localparam int CB_GCEN  = 1;
   localparam int CB_EN    = 2;
   localparam int CB_BSEL  = 3;

   // register offsets
   localparam int OFF_CTRL = 0;
   localparam int OFF_STAT = 1;
   localparam int OFF_IEN  = 2;
   localparam int OFF_OWN  = 3;
   localparam int OFF_DATA = 4;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_RHOLD,
      ST_TWAIT, ST_TX, ST_TACK, ST_WSTOP
   } tgt_state_e;
endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
   parameter int WIDTH = 2,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/tgt_busev.sv
module tgt_busev (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
   assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tgt_engine.sv
module tgt_engine
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              en,
   input  logic              gc_en,
   input  logic              fnack,
   input  logic [ADR7_W-1:0] own,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              flag_rx,
   input  logic              flag_empty,
   output logic              sda_oe,
   output logic              scl_oe,
   output logic [STAT_W-1:0] ev_set,
   output logic              ev_addr,
   output logic              rw,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] live_byte
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   tgt_state_e        st;
   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              rw_q, ack_q;

   logic ok, got_byte, tx_last, addr_hit, gc_hit, hit;

   assign ok       = en && !bus_start && !bus_stop;
   assign got_byte = (cnt == CNT_W'(BYTE_W));
   assign tx_last  = (cnt == CNT_W'(BYTE_W - 1));
   assign addr_hit = (sh[BYTE_W-1:1] == own);
   assign gc_hit   = gc_en && (sh[BYTE_W-1:1] == '0) && !sh[0];
   assign hit      = addr_hit || gc_hit;

   always_comb begin
      ev_set           = '0;
      ev_addr          = ok && (st == ST_ADDR) && scl_fall && got_byte && hit;
      ev_set[SB_ADDR]  = ev_addr;
      ev_set[SB_GCALL] = ev_addr && gc_hit;
      ev_set[SB_RXD]   = ok && (st == ST_RX) && scl_fall && got_byte;
      ev_set[SB_TXD]   = ok && (st == ST_TACK) && scl_rise;
      ev_set[SB_EMPTY] = ok && scl_fall &&
                         (((st == ST_AACK) && rw_q) || ((st == ST_TACK) && ack_q));
      ev_set[SB_STOP]  = en && bus_stop && (st != ST_IDLE);
   end

   assign rw        = sh[0];
   assign rx_valid  = ev_set[SB_RXD];
   assign live_byte = sh;
   assign scl_oe    = ((st == ST_RHOLD) && flag_rx) || ((st == ST_TWAIT) && flag_empty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sh     <= '0;
         cnt    <= '0;
         sda_oe <= 1'b0;
         rw_q   <= 1'b0;
         ack_q  <= 1'b0;
      end else if (!en) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (bus_start) begin
         st     <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (bus_stop) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (st)
            ST_ADDR, ST_RX: begin
               if (scl_rise && !got_byte) begin
                  sh  <= {sh[BYTE_W-2:0], sda_s};
                  cnt <= cnt + 1'b1;
               end
               if (scl_fall && got_byte) begin
                  if (st == ST_RX) begin
                     sda_oe <= !fnack;
                     st     <= ST_RACK;
                  end else if (hit) begin
                     sda_oe <= 1'b1;
                     rw_q   <= sh[0];
                     st     <= ST_AACK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_AACK: if (scl_fall) begin
               sda_oe <= 1'b0;
               cnt    <= '0;
               st     <= rw_q ? ST_TWAIT : ST_RX;
            end
            ST_RACK: if (scl_fall) begin
               sda_oe <= 1'b0;
               st     <= ST_RHOLD;
            end
            ST_RHOLD: if (!flag_rx) begin
               cnt <= '0;
               st  <= ST_RX;
            end
            ST_TWAIT: if (!flag_empty) begin
               sh     <= tx_byte;
               sda_oe <= !tx_byte[BYTE_W-1];
               cnt    <= '0;
               st     <= ST_TX;
            end
            ST_TX: if (scl_fall) begin
               if (tx_last) begin
                  sda_oe <= 1'b0;
                  st     <= ST_TACK;
               end else begin
                  sh     <= sh << 1;
                  sda_oe <= !sh[BYTE_W-2];
                  cnt    <= cnt + 1'b1;
               end
            end
            ST_TACK: begin
               if (scl_rise) ack_q <= !sda_s;
               if (scl_fall) st <= ack_q ? ST_TWAIT : ST_WSTOP;
            end
            ST_IDLE, ST_WSTOP: ;
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$stable(sda_oe)) |-> !scl_s); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe); // R12
   AST_FORCED_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set[SB_RXD] && fnack) |=> !sda_oe); // R5
endmodule

// File: rtl/tgt_regfile.sv
module tgt_regfile
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic [STAT_W-1:0] ev_set,
   input  logic              ev_addr,
   input  logic              rw,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] live_byte,
   output logic [CTRL_W-1:0] ctrl,
   output logic [ADR7_W-1:0] own,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [STAT_W-1:0] stat,
   output logic              irq
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("tgt_regfile: ADDR_W must reach offset 4");
      end
   endgenerate

   localparam logic [STAT_W-1:0] MODE_MASK = STAT_W'(1) << SB_TXMODE;

   logic [STAT_W-1:0] ien;
   logic [BYTE_W-1:0] dat;
   logic              sel_ctrl, sel_stat, sel_ien, sel_own, sel_data;

   assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
   assign sel_stat = (addr == ADDR_W'(OFF_STAT));
   assign sel_ien  = (addr == ADDR_W'(OFF_IEN));
   assign sel_own  = (addr == ADDR_W'(OFF_OWN));
   assign sel_data = (addr == ADDR_W'(OFF_DATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         ien  <= '0;
         own  <= '0;
         dat  <= '0;
         stat <= '0;
      end else begin
         if (we && sel_ctrl) ctrl <= wdata[CTRL_W-1:0];
         if (we && sel_ien)  ien  <= wdata[STAT_W-1:0];
         if (we && sel_own)  own  <= wdata[ADR7_W-1:0];
         if (rx_valid)             dat <= live_byte;
         else if (we && sel_data)  dat <= wdata;
         for (int i = 0; i < STAT_W; i++) begin
            if (i == SB_TXMODE) begin
               if (ev_addr) stat[i] <= rw;
            end else begin
               stat[i] <= (stat[i] & !(we && sel_stat && !wdata[i])) | ev_set[i];
            end
         end
      end
   end

   assign tx_byte = dat;
   assign irq     = |(stat & ien);

   always_comb begin
      rdata = '0;
      if (sel_ctrl)      rdata[CTRL_W-1:0] = ctrl;
      else if (sel_stat) rdata[STAT_W-1:0] = stat;
      else if (sel_ien)  rdata[STAT_W-1:0] = ien;
      else if (sel_own)  rdata[ADR7_W-1:0] = own;
      else if (sel_data) rdata = ctrl[CB_BSEL] ? dat : live_byte;
   end

   AST_MODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ev_addr |=> (stat[SB_TXMODE] == $past(rw))); // R3
   AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_stat && !wdata[SB_STOP] && !ev_set[SB_STOP]) |=> !stat[SB_STOP]); // R10
   AST_MODE_WRITE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_stat && !ev_addr) |=> $stable(stat & MODE_MASK)); // R3
endmodule

// File: rtl/i2c_target_top.sv
module i2c_target_top
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CFG_ADDR_W  = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  scl_oe,
   output logic                  sda_oe,
   input  logic                  cfg_we,
   input  logic [CFG_ADDR_W-1:0] cfg_addr,
   input  logic [BYTE_W-1:0]     cfg_wdata,
   output logic [BYTE_W-1:0]     cfg_rdata,
   output logic                  irq
);
   logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic [STAT_W-1:0] ev_set, stat;
   logic              ev_addr, rw, rx_valid;
   logic [BYTE_W-1:0] live_byte, tx_byte;
   logic [CTRL_W-1:0] ctrl;
   logic [ADR7_W-1:0] own;

   tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

   tgt_busev u_ev (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop));

   tgt_engine u_eng (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop),
      .en(ctrl[CB_EN]), .gc_en(ctrl[CB_GCEN]), .fnack(ctrl[CB_FNACK]),
      .own(own), .tx_byte(tx_byte),
      .flag_rx(stat[SB_RXD]), .flag_empty(stat[SB_EMPTY]),
      .sda_oe(sda_oe), .scl_oe(scl_oe), .ev_set(ev_set), .ev_addr(ev_addr),
      .rw(rw), .rx_valid(rx_valid), .live_byte(live_byte));

   tgt_regfile #(.ADDR_W(CFG_ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .ev_set(ev_set),
      .ev_addr(ev_addr), .rw(rw), .rx_valid(rx_valid),
      .live_byte(live_byte), .ctrl(ctrl), .own(own),
      .tx_byte(tx_byte), .stat(stat), .irq(irq));

   AST_HOLD_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> !scl_s); // R4
endmodule

// File: tb/sim_i2c_target_top.sv
module sim_i2c_target_top;
   localparam int Q = 10;
   localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2, A_OWN = 3'd3, A_DATA = 3'd4;
   localparam logic [6:0] OWN = 7'h2A;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl_h = 1'b1, sda_h = 1'b1;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   wire  [7:0] cfg_rdata;
   wire        scl_oe, sda_oe, irq;
   wire        scl_ln = scl_h & ~scl_oe;
   wire        sda_ln = sda_h & ~sda_oe;

   int n_chk = 0, n_bad = 0;

   i2c_target_top u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q(input int n = Q);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
   endtask

   task automatic wait_hi();
      while (!scl_ln) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      sda_h = b; wait_q(); scl_h = 1'b1; wait_hi(); wait_q(); scl_h = 1'b0; wait_q();
   endtask

   task automatic bit_in(output logic b);
      sda_h = 1'b1; wait_q(); scl_h = 1'b1; wait_hi(); wait_q(Q/2);
      b = sda_ln; wait_q(Q/2); scl_h = 1'b0; wait_q();
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      send_bits(v, 8); bit_in(ack);
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic host_ack);
      for (int i = 7; i >= 0; i--) bit_in(v[i]);
      bit_out(host_ack);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; scl_h = 1'b1; wait_q(2*Q); sda_h = 1'b0; wait_q(); scl_h = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wait_q(); scl_h = 1'b1; wait_hi(); wait_q(); sda_h = 1'b1; wait_q();
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v); chk($sformatf("R1 reg %0d after reset", a), v, 8'h00);
      end
      chk("R1 scl_oe after reset", scl_oe, 1'b0);
      chk("R1 sda_oe after reset", sda_oe, 1'b0);
      chk("R1 irq after reset", irq, 1'b0);
   endtask

   task automatic t_miss();
      logic a; logic [7:0] v;
      bus_start(); send_byte({7'h2B, 1'b0}, a);
      chk("R2 foreign address not acked", a, 1'b1);
      bus_stop(); rd(A_STAT, v);
      chk("R2 R8 no flag after foreign address and STOP", v, 8'h00);
   endtask

   task automatic t_write();
      logic a; logic [7:0] v;
      bus_start(); send_byte({OWN, 1'b0}, a);
      chk("R2 own address acked", a, 1'b0);
      rd(A_STAT, v); chk("R2 R3 status after write-address match", v, 8'h01);
      send_byte(8'hA5, a); chk("R4 byte acked", a, 1'b0);
      chk("R4 SCL held while byte uncollected", scl_oe, 1'b1);
      rd(A_STAT, v); chk("R4 status after byte", v, 8'h03);
      rd(A_DATA, v); chk("R4 data port byte", v, 8'hA5);
      wr(A_STAT, 8'hFD); rd(A_STAT, v);
      chk("R10 zero clears, one keeps", v, 8'h01);
      wait_q(3); chk("R4 SCL released after clear", scl_oe, 1'b0);
      wr(A_CTRL, 8'h04); send_bits(8'h0C, 4); rd(A_DATA, v);
      chk("R13 live shift view mid-byte", v, 8'h5C);
      wr(A_CTRL, 8'h0C); send_bits(8'h03, 4); bit_in(a);
      chk("R4 second byte acked", a, 1'b0);
      rd(A_DATA, v); chk("R4 second byte stored", v, 8'hC3);
      wr(A_STAT, 8'h00); bus_stop(); rd(A_STAT, v);
      chk("R8 STOP flag after addressed write", v, 8'h10);
      wr(A_IEN, 8'h10); chk("R11 irq with enabled STOP flag", irq, 1'b1);
      wr(A_IEN, 8'h02); chk("R11 irq masked", irq, 1'b0);
      wr(A_IEN, 8'h00); wr(A_STAT, 8'h00);
   endtask

   task automatic t_nack();
      logic a; logic [7:0] v;
      wr(A_CTRL, 8'h0D); bus_start(); send_byte({OWN, 1'b0}, a);
      chk("R5 address still acked", a, 1'b0);
      send_byte(8'h3C, a); chk("R5 forced NACK on data byte", a, 1'b1);
      rd(A_STAT, v); chk("R5 received flag set despite NACK", v, 8'h03);
      rd(A_DATA, v); chk("R5 NACKed byte stored", v, 8'h3C);
      wr(A_CTRL, 8'h0C); wr(A_STAT, 8'h00); bus_stop(); wr(A_STAT, 8'h00);
   endtask

   task automatic t_read();
      logic a; logic [7:0] v;
      bus_start(); send_byte({OWN, 1'b1}, a);
      chk("R2 read address acked", a, 1'b0);
      rd(A_STAT, v); chk("R3 R6 read-mode, empty and match flags", v, 8'h29);
      chk("R6 SCL held until data supplied", scl_oe, 1'b1);
      wr(A_DATA, 8'h96); wr(A_STAT, 8'h00); rd(A_STAT, v);
      chk("R3 mode bit survives status write", v, 8'h20);
      recv_byte(v, 1'b0); chk("R6 first byte MSB first", v, 8'h96);
      rd(A_STAT, v); chk("R6 transmitted and empty after host ACK", v, 8'h2C);
      wr(A_DATA, 8'h5A); wr(A_STAT, 8'h00);
      recv_byte(v, 1'b1); chk("R6 second byte", v, 8'h5A);
      rd(A_STAT, v); chk("R7 no empty flag after host NACK", v, 8'h24);
      chk("R7 SCL not held after NACK", scl_oe, 1'b0);
      bit_in(a); chk("R7 SDA not driven after NACK", a, 1'b1);
      bus_stop(); rd(A_STAT, v); chk("R8 STOP after read", v, 8'h34);
      wr(A_STAT, 8'h00);
   endtask

   task automatic t_gcall();
      logic a; logic [7:0] v;
      bus_start(); send_byte(8'h00, a);
      chk("R9 general call ignored when disabled", a, 1'b1);
      bus_stop(); rd(A_STAT, v); chk("R9 no flags when disabled", v, 8'h20);
      wr(A_CTRL, 8'h0E); bus_start(); send_byte(8'h00, a);
      chk("R9 general call acked when enabled", a, 1'b0);
      rd(A_STAT, v); chk("R9 general call flags", v, 8'h41);
      bus_stop(); wr(A_STAT, 8'h00); wr(A_CTRL, 8'h0C);
   endtask

   task automatic t_disable();
      logic a; logic [7:0] v;
      wr(A_CTRL, 8'h08); bus_start(); send_byte({OWN, 1'b0}, a);
      chk("R12 no ack while disabled", a, 1'b1);
      chk("R12 SCL not held while disabled", scl_oe, 1'b0);
      bus_stop(); rd(A_STAT, v); chk("R12 no flags while disabled", v, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wait_q(2);
      t_reset();
      wr(A_OWN, {1'b0, OWN});
      wr(A_CTRL, 8'h0C);
      t_miss();
      t_write();
      t_nack();
      t_read();
      t_gcall();
      t_disable();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule